// File: doc/BRIEF.md
# In-Band Loopback Code Detector

This block watches a received T1 bit stream for two repeating in-band codes: one that asks the far end to loop up and one that asks it to loop down. Each code has its own pattern and its own length of 4 to 7 bits. A code shorter than 4 bits is programmed as two copies of itself, so the 3-bit code 001 is entered as 001001 with length 6. Every accepted bit advances a phase counter that wraps at the code length. At the last bit of each code period, the most recent code-length bits are compared with every cyclic rotation of the pattern. Because of this, the stream may arrive at any phase alignment.

A programmable number of consecutive matching periods sets a live status bit for that code. The same number of consecutive non-matching periods clears it. When a status bit rises, it also sets a sticky interrupt-status bit. That bit stays set until software clears it with a write-one-to-clear strobe. A sticky bit whose enable is set raises the shared alarm interrupt line. The block never starts a loopback itself. Software reads the status and decides what to do. In E1 mode both detectors are held idle.

Top module: `inband_loop_det`

## Requirements
- R1: After reset, all five outputs are low.
- R2: The two detectors are independent. The loop-up detector uses `up_pat_i`/`up_len_i` and the loop-down detector uses `dn_pat_i`/`dn_len_i`. Length code 0, 1, 2 and 3 selects 4, 5, 6 and 7 bits.
- R3: Pattern bit `len-1` is the first bit of the code on the line and bit 0 is the last. Any cyclic rotation of the code is accepted, so any phase alignment works. Pattern bits at position `len` and above are ignored.
- R4: The phase counter starts at 0 after reset or E1 mode and counts accepted bits modulo the length. At each period's final bit, the period is good only if the last `len` accepted bits, oldest first, equal a rotation of the pattern.
- R5: A status bit sets at the edge that accepts the final bit of the `qual_i`-th consecutive good period. It clears at the final bit of the `qual_i`-th consecutive bad period. A `qual_i` of 0 acts as 1.
- R6: A bit presented while `rx_bit_en_i` is low has no effect on any detector.
- R7: Each interrupt-status bit sets at the same edge its status bit rises. It stays set until its clear strobe is high at an edge: `isr_clr_i[0]` clears loop-up and `isr_clr_i[1]` clears loop-down. When set and clear happen at the same edge, set wins.
- R8: `alarm_irq_o` is high exactly when (`up_isr_o` and `irq_en_i[0]`) or (`dn_isr_o` and `irq_en_i[1]`), with no added cycle.
- R9: While `t1_mode_i` is low, incoming bits are ignored. Both status bits, the phase counters, the period counts and the bit history are cleared. The interrupt-status bits are unchanged.
- R10: The standard T1 codes are told apart. Loop-up 00001 (length 5) and loop-down 001001 (length 6) are each detected while the other detector stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t1_mode_i | input | 1 | 1 = T1 line rate, detectors run; 0 = E1, detectors idle |
| rx_bit_i | input | 1 | Received unipolar data bit |
| rx_bit_en_i | input | 1 | Qualifies `rx_bit_i` for this cycle |
| up_pat_i | input | 7 | Loop-up pattern, first line bit in the top used position |
| up_len_i | input | 2 | Loop-up length code (0..3 gives 4..7 bits) |
| dn_pat_i | input | 7 | Loop-down pattern |
| dn_len_i | input | 2 | Loop-down length code |
| qual_i | input | QUAL_W | Consecutive periods needed to set or clear status |
| irq_en_i | input | 2 | Interrupt enables: bit 0 loop-up, bit 1 loop-down |
| isr_clr_i | input | 2 | Write-one-to-clear strobes for the sticky bits |
| up_stat_o | output | 1 | Loop-up code present |
| dn_stat_o | output | 1 | Loop-down code present |
| up_isr_o | output | 1 | Sticky loop-up detection |
| dn_isr_o | output | 1 | Sticky loop-down detection |
| alarm_irq_o | output | 1 | Combined alarm interrupt request |

## Verification
A phase counter that slips or a history that holds a stale bit shows up as a status edge at the wrong place. The edge appears one or more code periods early or late, so the bench compares both status bits against its own model after every accepted bit. A saturating counter that wraps or fails to reset makes a release or detection happen one period off the expected edge. This is seen within `qual_i` periods of the first change in the stream. Faults in the sticky latch or the enable path appear at `up_isr_o`, `dn_isr_o` or `alarm_irq_o` in the same cycle as the status edge or the clear strobe.

// File: rtl/inband_pkg.sv
package inband_pkg;
  localparam int unsigned PAT_W   = 7;
  localparam int unsigned MIN_LEN = 4;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned PH_W    = $clog2(PAT_W + 1);
  localparam int unsigned N_DET   = 2;

  typedef logic [PAT_W-1:0] pat_t;
  typedef logic [PH_W-1:0]  phase_t;

  function automatic phase_t len_of(input logic [SEL_W-1:0] sel);
    return phase_t'(MIN_LEN) + phase_t'(sel);
  endfunction

  // win[0] is newest; aligned code gives win[i] == pat[i]
  function automatic logic rot_match(input pat_t win, input pat_t pat, input phase_t len);
    logic hit;
    logic same;
    int   k;
    hit = 1'b0;
    for (int r = 0; r < int'(PAT_W); r++) begin
      same = (r < int'(len));
      for (int i = 0; i < int'(PAT_W); i++) begin
        if (i < int'(len)) begin
          k = (i + r) % int'(len);
          if (win[i] != pat[k]) same = 1'b0;
        end
      end
      hit = hit | same;
    end
    return hit;
  endfunction
endpackage

// File: rtl/inband_code_matcher.sv
module inband_code_matcher
  import inband_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  pat_t             pat_i,
  input  logic [SEL_W-1:0] len_sel_i,
  output logic             done_o,
  output logic             good_o
);
  pat_t   hist_q;
  phase_t phase_q;
  phase_t len;
  pat_t   win;
  logic   take;
  logic   last;

  assign len  = len_of(len_sel_i);
  assign win  = {hist_q[PAT_W-2:0], bit_i};
  assign take = active_i & bit_en_i;
  assign last = (phase_q >= len - phase_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      phase_q <= '0;
    end else if (!active_i) begin
      hist_q  <= '0;
      phase_q <= '0;
    end else if (take) begin
      hist_q  <= win;
      phase_q <= last ? '0 : phase_q + phase_t'(1);
    end
  end

  assign done_o = take & last;
  assign good_o = rot_match(win, pat_i, len);
endmodule

// File: rtl/inband_qualifier.sv
module inband_qualifier #(
  parameter int unsigned QUAL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              done_i,
  input  logic              good_i,
  input  logic [QUAL_W-1:0] qual_i,
  output logic              stat_o,
  output logic              rise_o
);
  logic [QUAL_W-1:0] thr;
  logic [QUAL_W-1:0] good_q;
  logic [QUAL_W-1:0] bad_q;
  logic              stat_q;
  logic              good_hit;
  logic              bad_hit;

  assign thr      = (qual_i == '0) ? QUAL_W'(1) : qual_i;
  assign good_hit = done_i & good_i & (good_q >= thr - QUAL_W'(1));
  assign bad_hit  = done_i & ~good_i & (bad_q >= thr - QUAL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      bad_q  <= '0;
      stat_q <= 1'b0;
    end else if (!active_i) begin
      good_q <= '0;
      bad_q  <= '0;
      stat_q <= 1'b0;
    end else if (done_i) begin
      if (good_i) begin
        bad_q <= '0;
        if (good_q < thr) good_q <= good_q + QUAL_W'(1);
        if (good_hit) stat_q <= 1'b1;
      end else begin
        good_q <= '0;
        if (bad_q < thr) bad_q <= bad_q + QUAL_W'(1);
        if (bad_hit) stat_q <= 1'b0;
      end
    end
  end

  assign stat_o = stat_q;
  assign rise_o = active_i & good_hit & ~stat_q;
endmodule

// File: rtl/inband_isr_latch.sv
module inband_isr_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic isr_o
);
  logic isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     isr_q <= 1'b0;
    else if (set_i)  isr_q <= 1'b1;
    else if (clr_i)  isr_q <= 1'b0;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/inband_loop_det.sv
module inband_loop_det
  import inband_pkg::*;
#(
  parameter int unsigned QUAL_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  t1_mode_i,
  input  logic                  rx_bit_i,
  input  logic                  rx_bit_en_i,
  input  logic [PAT_W-1:0]      up_pat_i,
  input  logic [SEL_W-1:0]      up_len_i,
  input  logic [PAT_W-1:0]      dn_pat_i,
  input  logic [SEL_W-1:0]      dn_len_i,
  input  logic [QUAL_W-1:0]     qual_i,
  input  logic [N_DET-1:0]      irq_en_i,
  input  logic [N_DET-1:0]      isr_clr_i,
  output logic                  up_stat_o,
  output logic                  dn_stat_o,
  output logic                  up_isr_o,
  output logic                  dn_isr_o,
  output logic                  alarm_irq_o
);
  pat_t             pat_a [N_DET];
  logic [SEL_W-1:0] len_a [N_DET];
  logic [N_DET-1:0] done;
  logic [N_DET-1:0] good;
  logic [N_DET-1:0] stat;
  logic [N_DET-1:0] rise;
  logic [N_DET-1:0] isr;

  assign pat_a[0] = up_pat_i;
  assign pat_a[1] = dn_pat_i;
  assign len_a[0] = up_len_i;
  assign len_a[1] = dn_len_i;

  for (genvar g = 0; g < N_DET; g++) begin : g_det
    inband_code_matcher i_match (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (t1_mode_i),
      .bit_en_i  (rx_bit_en_i),
      .bit_i     (rx_bit_i),
      .pat_i     (pat_a[g]),
      .len_sel_i (len_a[g]),
      .done_o    (done[g]),
      .good_o    (good[g])
    );

    inband_qualifier #(.QUAL_W(QUAL_W)) i_qual (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (t1_mode_i),
      .done_i   (done[g]),
      .good_i   (good[g]),
      .qual_i   (qual_i),
      .stat_o   (stat[g]),
      .rise_o   (rise[g])
    );

    inband_isr_latch i_isr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (rise[g]),
      .clr_i  (isr_clr_i[g]),
      .isr_o  (isr[g])
    );
  end

  assign up_stat_o   = stat[0];
  assign dn_stat_o   = stat[1];
  assign up_isr_o    = isr[0];
  assign dn_isr_o    = isr[1];
  assign alarm_irq_o = |(isr & irq_en_i);
endmodule

// File: rtl/inband_loop_det_chk.sv
module inband_loop_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       t1_mode_i,
  input logic       rx_bit_en_i,
  input logic [1:0] isr_clr_i,
  input logic       up_stat_o,
  input logic       dn_stat_o,
  input logic       up_isr_o,
  input logic       dn_isr_o,
  input logic       alarm_irq_o
);
  AST_E1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t1_mode_i |=> (!up_stat_o && !dn_stat_o)); // R9

  AST_NO_EN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_mode_i && !rx_bit_en_i) |=> ($stable(up_stat_o) && $stable(dn_stat_o))); // R6

  AST_UP_RISE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_stat_o) |-> up_isr_o); // R7

  AST_DN_RISE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_stat_o) |-> dn_isr_o); // R7

  AST_UP_ISR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_isr_o && !isr_clr_i[0]) |=> up_isr_o); // R7

  AST_DN_ISR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_isr_o && !isr_clr_i[1]) |=> dn_isr_o); // R7

  AST_UP_ISR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_isr_o) |-> $rose(up_stat_o)); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_isr_o && !dn_isr_o) |-> !alarm_irq_o); // R8
endmodule

bind inband_loop_det inband_loop_det_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .t1_mode_i   (t1_mode_i),
  .rx_bit_en_i (rx_bit_en_i),
  .isr_clr_i   (isr_clr_i),
  .up_stat_o   (up_stat_o),
  .dn_stat_o   (dn_stat_o),
  .up_isr_o    (up_isr_o),
  .dn_isr_o    (dn_isr_o),
  .alarm_irq_o (alarm_irq_o)
);

// File: tb/test_inband_loop_det.sv
module test_inband_loop_det;
  localparam int CLK_PERIOD = 10;
  localparam int QW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          t1_mode = 1'b0;
  logic          rx_bit = 1'b0;
  logic          rx_en = 1'b0;
  logic [6:0]    up_pat = '0;
  logic [1:0]    up_len = '0;
  logic [6:0]    dn_pat = '0;
  logic [1:0]    dn_len = '0;
  logic [QW-1:0] qual = '0;
  logic [1:0]    irq_en = '0;
  logic [1:0]    isr_clr = '0;
  logic          up_stat, dn_stat, up_isr, dn_isr, alarm;

  int n_chk = 0;
  int n_bad = 0;

  logic [6:0] m_hist [2];
  int         m_phase [2];
  int         m_good [2];
  int         m_bad [2];
  logic       m_stat [2];
  logic       m_isr [2];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  inband_loop_det #(.QUAL_W(QW)) i_inband_loop_det (
    .clk_i(clk), .rst_ni(rst_n), .t1_mode_i(t1_mode), .rx_bit_i(rx_bit),
    .rx_bit_en_i(rx_en), .up_pat_i(up_pat), .up_len_i(up_len),
    .dn_pat_i(dn_pat), .dn_len_i(dn_len), .qual_i(qual), .irq_en_i(irq_en),
    .isr_clr_i(isr_clr), .up_stat_o(up_stat), .dn_stat_o(dn_stat),
    .up_isr_o(up_isr), .dn_isr_o(dn_isr), .alarm_irq_o(alarm)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic cyc_hit(input logic [6:0] win, input logic [6:0] pat, input int len);
    logic [13:0] dbl;
    logic [6:0]  msk;
    msk = 7'((1 << len) - 1);
    dbl = 14'(pat & msk) | (14'(pat & msk) << len);
    for (int s = 0; s < len; s++)
      if ((7'(dbl >> s) & msk) == (win & msk)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_clear();
    for (int d = 0; d < 2; d++) begin
      m_hist[d] = '0; m_phase[d] = 0; m_good[d] = 0; m_bad[d] = 0; m_stat[d] = 1'b0;
    end
  endtask

  task automatic model_step();
    logic [6:0] pat;
    logic [6:0] win;
    logic       set;
    int         len, thr;
    for (int d = 0; d < 2; d++) begin
      set = 1'b0;
      pat = (d == 0) ? up_pat : dn_pat;
      len = 4 + int'((d == 0) ? up_len : dn_len);
      thr = (qual == 0) ? 1 : int'(qual);
      if (!t1_mode) begin
        m_hist[d] = '0; m_phase[d] = 0; m_good[d] = 0; m_bad[d] = 0; m_stat[d] = 1'b0;
      end else if (rx_en) begin
        win = {m_hist[d][5:0], rx_bit};
        m_hist[d] = win;
        if (m_phase[d] == len - 1) begin
          m_phase[d] = 0;
          if (cyc_hit(win, pat, len)) begin
            m_bad[d] = 0;
            if (m_good[d] < thr) m_good[d]++;
            if (m_good[d] >= thr && !m_stat[d]) begin m_stat[d] = 1'b1; set = 1'b1; end
          end else begin
            m_good[d] = 0;
            if (m_bad[d] < thr) m_bad[d]++;
            if (m_bad[d] >= thr) m_stat[d] = 1'b0;
          end
        end else begin
          m_phase[d]++;
        end
      end
      if (set) m_isr[d] = 1'b1;
      else if (isr_clr[d]) m_isr[d] = 1'b0;
    end
  endtask

  task automatic compare_all();
    chk("R5 up_stat", up_stat, m_stat[0]);
    chk("R5 dn_stat", dn_stat, m_stat[1]);
    chk("R7 up_isr", up_isr, m_isr[0]);
    chk("R7 dn_isr", dn_isr, m_isr[1]);
    chk("R8 alarm", alarm, (m_isr[0] & irq_en[0]) | (m_isr[1] & irq_en[1]));
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic step(input logic b, input logic en, input logic [1:0] clr);
    rx_bit = b; rx_en = en; isr_clr = clr;
    @(posedge clk); #1;
    model_step();
    compare_all();
    @(negedge clk);
    isr_clr = 2'b00;
  endtask

  task automatic noise_bit(input logic en);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    step(lfsr[0], en, 2'b00);
  endtask

  task automatic idle_restart();
    t1_mode = 1'b0;
    step(1'b0, 1'b0, 2'b11);
    t1_mode = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int len, off, cfg;
    logic [6:0] pat;
    for (int d = 0; d < 2; d++) m_isr[d] = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 up_stat", up_stat, 1'b0);
    chk("R1 dn_stat", dn_stat, 1'b0);
    chk("R1 up_isr", up_isr, 1'b0);
    chk("R1 dn_isr", dn_isr, 1'b0);
    chk("R1 alarm", alarm, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: aligned 1011, length 4, one period
    up_pat = 7'b0001011; up_len = 2'd0; dn_pat = 7'b0000000; dn_len = 2'd0; qual = 1;
    idle_restart();
    step(1'b1, 1'b1, 2'b00);
    step(1'b0, 1'b1, 2'b00);
    step(1'b1, 1'b1, 2'b00);
    chk("R4 not before period end", up_stat, 1'b0);
    step(1'b1, 1'b1, 2'b00);
    chk("R4 set at period end", up_stat, 1'b1);

    // R6: disabled bits ignored
    for (int i = 0; i < 20; i++) noise_bit(1'b0);
    chk("R6 up_stat held", up_stat, 1'b1);
    chk("R6 dn_stat held", dn_stat, 1'b0);

    // R9: E1 clears status, keeps sticky bits
    t1_mode = 1'b0;
    step(1'b1, 1'b1, 2'b00);
    chk("R9 up_stat cleared", up_stat, 1'b0);
    chk("R9 up_isr kept", up_isr, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 2'b00);
    chk("R9 bits ignored", up_stat, 1'b0);
    t1_mode = 1'b1;

    // sweep lengths, qualify counts, offsets, enables
    cfg = 0;
    for (int sel = 0; sel < 4; sel++) begin
      for (int q = 0; q < 4; q++) begin
        len = 4 + sel;
        pat = 7'b1011011 | (7'(cfg) << len);   // R3: upper bits are junk
        up_pat = pat; up_len = 2'(sel);
        dn_pat = 7'b0000000; dn_len = 2'((sel + 1) % 4);
        qual = QW'(q); irq_en = 2'(cfg % 4);
        off = cfg % len;
        idle_restart();
        for (int i = 0; i < 3 * len; i++) noise_bit(i % 3 != 2);
        for (int k = 0; k < (((q == 0) ? 1 : q) + 2) * len + off; k++) begin
          step(pat[len - 1 - ((k + off) % len)], 1'b1, (cfg % 5 == 0) ? 2'b01 : 2'b00);
          if (k % 4 == 3) step(~rx_bit, 1'b0, 2'b00);
        end
        chk("R3 rotated code detected", up_stat, 1'b1);
        chk("R2 dn independent", dn_stat, m_stat[1]);
        for (int k = 0; k < (((q == 0) ? 1 : q) + 1) * len; k++) step(1'b1, 1'b1, 2'b00);
        chk("R5 released", up_stat, 1'b0);
        step(1'b1, 1'b0, 2'b11);
        chk("R7 cleared", up_isr, 1'b0);
        cfg++;
      end
    end

    // R10: standard codes
    up_pat = 7'b0000001; up_len = 2'd1;
    dn_pat = 7'b0001001; dn_len = 2'd2;
    qual = 2; irq_en = 2'b11;
    idle_restart();
    for (int k = 0; k < 36; k++) step((k % 3) == 2, 1'b1, 2'b00);
    chk("R10 loop-down seen", dn_stat, 1'b1);
    chk("R10 loop-up clear", up_stat, 1'b0);
    for (int k = 0; k < 40; k++) step((k % 5) == 4, 1'b1, 2'b00);
    chk("R10 loop-up seen", up_stat, 1'b1);
    chk("R10 loop-down released", dn_stat, 1'b0);
    step(1'b0, 1'b0, 2'b01);
    chk("R7 up cleared only", up_isr, 1'b0);
    chk("R7 dn kept", dn_isr, 1'b1);
    chk("R8 alarm from dn", alarm, 1'b1);
    irq_en = 2'b01;
    #1;
    chk("R8 alarm masked", alarm, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule